// File: doc/BRIEF.md
# Deferred Cache Maintenance Operation Tracker

This block sits beside a processor pipeline and takes in system-control coprocessor write operations. Each one is named by a register tuple of four fields (primary register, first opcode, secondary register, second opcode) and carries a 32-bit operand. The block looks at the tuple and decides whether the maintenance effect may go out at once or has to wait for a barrier. Operations that wait are parked in a small ordered queue. They are handed to the downstream cache and predictor maintenance logic only after a barrier of sufficient strength has been observed.

Every operation falls into one of four release classes. Immediate operations need no barrier. Data-memory-barrier operations are freed by a memory barrier or by a synchronization barrier. Data-sync operations are freed only by a synchronization barrier. Instruction-sync operations are freed by an instruction barrier, an exception entry or an exception return. Those last three events free every class, so they empty the queue completely. Operations leave on a valid/ready port in exactly the order they were issued. An operation whose barrier has already arrived waits behind any older one that is still pending. A deferral enable turns off the holding entirely.

Top module: `mop_defer_tracker`

## Requirements
In the requirements below, a tuple written (7,0,m,o) means primary register 7, first opcode 0, secondary register m and second opcode o.

- R1: The tuples (7,0,1,0), (7,0,5,0) and (7,0,5,1) are held. Only a synchronization barrier (`bar_dsb`) or a full drain releases them. A memory barrier alone does not.
- R2: The tuples (7,0,6,2), (7,0,10,2) and (7,0,14,2) are held until either `bar_dmb` or `bar_dsb` is seen.
- R3: Every tuple not named in R1, R2, R4 or R5 is held until `bar_isb`, `exc_entry` or `exc_return` is seen. This includes (7,0,1,6), (7,0,5,6) and (7,0,5,7). Any of those three events releases pending operations of every class.
- R4: The tuples (7,0,6,1), (7,0,10,1), (7,0,11,1) and (7,0,14,1) need no barrier. When the queue is empty, such an operation appears on the release port in the same cycle it is issued.
- R5: The tuple (7,0,5,4) is never queued and never released. It acts as an instruction barrier event in the cycle it is issued, and it is accepted even while `iss_stall` is high.
- R6: While `defer_en` is 0, every operation is released without a barrier. If the queue is empty, it appears on the release port in the cycle it is issued.
- R7: Operations are released strictly in issue order. A younger operation whose barrier has arrived is not released while an older one is still pending.
- R8: `iss_stall` is 1 exactly while DEPTH operations are held. Any issue other than the R5 tuple that arrives while `iss_stall` is 1 is ignored.
- R9: Once `rel_valid` is 1 with `rel_ready` 0, `rel_valid` and all release fields stay unchanged until the transfer is taken.
- R10: After reset the queue is empty, `rel_valid` is 0 and `iss_stall` is 0.
- R11: A barrier strobe that is high in the same cycle an operation is issued applies to that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| defer_en | input | 1 | 1: hold operations until their barrier; 0: release without barrier |
| iss_valid | input | 1 | An operation is presented this cycle |
| iss_crn | input | 4 | Primary register number of the operation |
| iss_op1 | input | 3 | First opcode of the operation |
| iss_crm | input | 4 | Secondary register number of the operation |
| iss_op2 | input | 3 | Second opcode of the operation |
| iss_data | input | DATA_W | Operand (address or data) |
| iss_stall | output | 1 | Queue full; issues other than the barrier tuple are ignored |
| bar_dmb | input | 1 | Memory barrier observed |
| bar_dsb | input | 1 | Synchronization barrier observed |
| bar_isb | input | 1 | Instruction barrier observed |
| exc_entry | input | 1 | Exception entry observed |
| exc_return | input | 1 | Exception return observed |
| rel_valid | output | 1 | A released operation is offered |
| rel_ready | input | 1 | Downstream accepts the offered operation |
| rel_crn | output | 4 | Primary register number of the released operation |
| rel_op1 | output | 3 | First opcode of the released operation |
| rel_crm | output | 4 | Secondary register number of the released operation |
| rel_op2 | output | 3 | Second opcode of the released operation |
| rel_data | output | DATA_W | Operand of the released operation |

## Verification
The bench issues every combination of secondary register and second opcode under primary register 7 with first opcode 0, plus tuples with other primary registers and opcodes. After each issue it applies the barriers from weakest to strongest, so a misclassified tuple shows up by being released one barrier too early or too late. A wrong class table would, for example, let an instruction-cache invalidate out on a memory barrier, or hold a by-address clean. Separate sequences go after three further cases:
- A younger memory-barrier operation sitting behind an older sync-barrier one. A design that let it overtake would release the younger operand first.
- A full queue that gets one more issue followed by the barrier tuple. A design with a wrong full flag would either lose the barrier or accept the fifth operation.
- A barrier arriving in the same cycle as its operation. A design that misses this would leave the operation stuck.

// File: rtl/mop_pkg.sv
package mop_pkg;

   typedef enum logic [1:0] {
      CLS_NOW = 2'd0,
      CLS_DMB = 2'd1,
      CLS_DSB = 2'd2,
      CLS_ISB = 2'd3
   } mop_cls_e;

   typedef struct packed {
      logic [3:0] crn;
      logic [2:0] op1;
      logic [3:0] crm;
      logic [2:0] op2;
   } mop_enc_t;

   // True when a pending entry of class c is freed by the given events
   function automatic logic cls_freed(mop_cls_e c, logic ev_dmb, logic ev_dsb,
                                      logic ev_all);
      logic r;
      unique case (c)
         CLS_NOW: r = 1'b1;
         CLS_DMB: r = ev_dmb | ev_dsb | ev_all;
         CLS_DSB: r = ev_dsb | ev_all;
         default: r = ev_all;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/mop_classify.sv
module mop_classify
   import mop_pkg::*;
(
   input  mop_enc_t enc,
   output mop_cls_e cls,
   output logic     is_sync
);

   always_comb begin
      cls     = CLS_ISB;
      is_sync = 1'b0;
      if (enc.crn == 4'd7 && enc.op1 == 3'd0) begin
         unique case (enc.crm)
            4'd1: begin
               if (enc.op2 == 3'd0) cls = CLS_DSB;
            end
            4'd5: begin
               if (enc.op2 == 3'd0 || enc.op2 == 3'd1) cls = CLS_DSB;
               if (enc.op2 == 3'd4) is_sync = 1'b1;
            end
            4'd6, 4'd10, 4'd14: begin
               if (enc.op2 == 3'd1)      cls = CLS_NOW;
               else if (enc.op2 == 3'd2) cls = CLS_DMB;
            end
            4'd11: begin
               if (enc.op2 == 3'd1) cls = CLS_NOW;
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/mop_queue.sv
module mop_queue
   import mop_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  mop_enc_t          push_enc,
   input  logic [DATA_W-1:0] push_data,
   input  mop_cls_e          push_cls,
   input  logic              push_armed,
   input  logic              ev_dmb,
   input  logic              ev_dsb,
   input  logic              ev_all,
   input  logic              pop,
   output mop_enc_t          head_enc,
   output logic [DATA_W-1:0] head_data,
   output logic              head_armed,
   output logic              empty,
   output logic              full
);

   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [PW-1:0] LAST   = PW'(DEPTH - 1);
   localparam logic [CW-1:0] FULL_N = CW'(DEPTH);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   mop_enc_t          enc_q [DEPTH];
   logic [DATA_W-1:0] dat_q [DEPTH];
   mop_cls_e          cls_q [DEPTH];
   logic [DEPTH-1:0]  occ_q, arm_q;
   logic [PW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]     cnt_q;

   // pointer wrap: free wrap for power-of-two depth, compare otherwise
   generate
      if (POW2) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + PW'(1);
         assign rd_nxt = rd_ptr + PW'(1);
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + PW'(1);
         assign rd_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + PW'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         cnt_q <= cnt_q + CW'(push) - CW'(pop);
      end
   end

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         logic wr_here, rd_here;
         assign wr_here = push && (wr_ptr == PW'(g));
         assign rd_here = pop  && (rd_ptr == PW'(g));

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               occ_q[g] <= 1'b0;
               arm_q[g] <= 1'b0;
            end else if (wr_here) begin
               occ_q[g] <= 1'b1;
               arm_q[g] <= push_armed | cls_freed(push_cls, ev_dmb, ev_dsb, ev_all);
            end else if (rd_here) begin
               occ_q[g] <= 1'b0;
               arm_q[g] <= 1'b0;
            end else if (occ_q[g] && cls_freed(cls_q[g], ev_dmb, ev_dsb, ev_all)) begin
               arm_q[g] <= 1'b1;
            end
         end

         always_ff @(posedge clk) begin
            if (wr_here) begin
               enc_q[g] <= push_enc;
               dat_q[g] <= push_data;
               cls_q[g] <= push_cls;
            end
         end
      end
   endgenerate

   assign empty      = (cnt_q == '0);
   assign full       = (cnt_q == FULL_N);
   assign head_enc   = enc_q[rd_ptr];
   assign head_data  = dat_q[rd_ptr];
   assign head_armed = !empty && arm_q[rd_ptr];

endmodule

// File: rtl/mop_defer_tracker.sv
module mop_defer_tracker
   import mop_pkg::*;
#(
   parameter int DEPTH  = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              defer_en,
   input  logic              iss_valid,
   input  logic [3:0]        iss_crn,
   input  logic [2:0]        iss_op1,
   input  logic [3:0]        iss_crm,
   input  logic [2:0]        iss_op2,
   input  logic [DATA_W-1:0] iss_data,
   output logic              iss_stall,
   input  logic              bar_dmb,
   input  logic              bar_dsb,
   input  logic              bar_isb,
   input  logic              exc_entry,
   input  logic              exc_return,
   output logic              rel_valid,
   input  logic              rel_ready,
   output logic [3:0]        rel_crn,
   output logic [2:0]        rel_op1,
   output logic [3:0]        rel_crm,
   output logic [2:0]        rel_op2,
   output logic [DATA_W-1:0] rel_data
);

   generate
      if (DEPTH < 2)   begin : g_bad_depth $error("DEPTH must be at least 2"); end
      if (DATA_W < 1)  begin : g_bad_width $error("DATA_W must be positive"); end
   endgenerate

   mop_enc_t          iss_enc, head_enc, out_enc;
   mop_cls_e          iss_cls;
   logic              is_sync, ev_all, accept, immediate, bypass;
   logic              q_push, q_pop, q_empty, q_full, head_armed;
   logic [DATA_W-1:0] head_data;

   assign iss_enc = '{crn: iss_crn, op1: iss_op1, crm: iss_crm, op2: iss_op2};

   mop_classify u_cls (
      .enc     (iss_enc),
      .cls     (iss_cls),
      .is_sync (is_sync)
   );

   // barrier tuple counts as an instruction barrier event
   assign ev_all    = bar_isb | exc_entry | exc_return | (iss_valid & is_sync);
   assign accept    = iss_valid & !is_sync & !q_full;
   assign immediate = (iss_cls == CLS_NOW) | !defer_en;
   assign bypass    = accept & q_empty & immediate;

   assign q_push = accept & !(bypass & rel_ready);
   assign q_pop  = head_armed & rel_ready;

   mop_queue #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_q (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (q_push),
      .push_enc   (iss_enc),
      .push_data  (iss_data),
      .push_cls   (iss_cls),
      .push_armed (immediate),
      .ev_dmb     (bar_dmb),
      .ev_dsb     (bar_dsb),
      .ev_all     (ev_all),
      .pop        (q_pop),
      .head_enc   (head_enc),
      .head_data  (head_data),
      .head_armed (head_armed),
      .empty      (q_empty),
      .full       (q_full)
   );

   assign rel_valid = q_empty ? bypass : head_armed;
   assign out_enc   = q_empty ? iss_enc : head_enc;
   assign rel_data  = q_empty ? iss_data : head_data;
   assign rel_crn   = out_enc.crn;
   assign rel_op1   = out_enc.op1;
   assign rel_crm   = out_enc.crm;
   assign rel_op2   = out_enc.op2;
   assign iss_stall = q_full;

endmodule

// File: rtl/mop_defer_chk.sv
module mop_defer_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              defer_en,
   input logic              iss_valid,
   input logic              iss_stall,
   input logic [3:0]        iss_crn,
   input logic [2:0]        iss_op1,
   input logic [3:0]        iss_crm,
   input logic [2:0]        iss_op2,
   input logic [DATA_W-1:0] iss_data,
   input logic              bar_isb,
   input logic              exc_entry,
   input logic              exc_return,
   input logic              rel_valid,
   input logic              rel_ready,
   input logic [3:0]        rel_crn,
   input logic [2:0]        rel_op1,
   input logic [3:0]        rel_crm,
   input logic [2:0]        rel_op2,
   input logic [DATA_W-1:0] rel_data,
   input logic              q_empty
);

   logic base, sync_t, addr_t, take;
   assign base   = (iss_crn == 4'd7) && (iss_op1 == 3'd0);
   assign sync_t = base && iss_crm == 4'd5 && iss_op2 == 3'd4;
   assign addr_t = base && iss_op2 == 3'd1 &&
                   (iss_crm == 4'd6 || iss_crm == 4'd10 || iss_crm == 4'd11 || iss_crm == 4'd14);
   assign take   = rel_valid && rel_ready;

   // R9
   hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid && !rel_ready |=> rel_valid && $stable(rel_data) && $stable(rel_crn)
         && $stable(rel_op1) && $stable(rel_crm) && $stable(rel_op2));

   // R6
   defer_off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !defer_en && iss_valid && !sync_t && q_empty |-> rel_valid && rel_data == iss_data);

   // R4
   addr_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid && addr_t && q_empty |-> rel_valid && rel_data == iss_data);

   // R3
   drain_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bar_isb || exc_entry || exc_return || (iss_valid && sync_t)) && !q_empty && !take
         |=> rel_valid);

   // R5
   no_sync_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rel_valid |-> !(rel_crn == 4'd7 && rel_op1 == 3'd0 && rel_crm == 4'd5 && rel_op2 == 3'd4));

   // R10
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q_empty && !iss_valid |-> !rel_valid);

   // R8
   stall_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_stall |-> !q_empty);

endmodule

bind mop_defer_tracker mop_defer_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_mop_defer_tracker.sv
module tb_mop_defer_tracker;

   localparam int DEPTH  = 4;
   localparam int DATA_W = 32;

   logic clk = 1'b0, rst_n = 1'b0, defer_en = 1'b1, iss_valid = 1'b0;
   logic [3:0] iss_crn = '0, iss_crm = '0, rel_crn, rel_crm;
   logic [2:0] iss_op1 = '0, iss_op2 = '0, rel_op1, rel_op2;
   logic [DATA_W-1:0] iss_data = '0, rel_data;
   logic iss_stall, rel_valid, rel_ready = 1'b0;
   logic bar_dmb = 1'b0, bar_dsb = 1'b0, bar_isb = 1'b0, exc_entry = 1'b0, exc_return = 1'b0;

   int checks = 0, errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mop_defer_tracker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dut (.*);

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // class: 0 none needed, 1 mem barrier, 2 sync barrier, 3 instr barrier, 4 barrier tuple
   function automatic int want_cls(int crn, int op1, int crm, int op2);
      if (crn != 7 || op1 != 0) return 3;
      if (crm == 5 && op2 == 4) return 4;
      if ((crm == 1 && op2 == 0) || (crm == 5 && op2 <= 1)) return 2;
      if (op2 == 1 && (crm == 6 || crm == 10 || crm == 11 || crm == 14)) return 0;
      if (op2 == 2 && (crm == 6 || crm == 10 || crm == 14)) return 1;
      return 3;
   endfunction

   function automatic string tag_of(int c);
      case (c)
         0: return "R4";
         1: return "R2";
         2: return "R1";
         4: return "R5";
         default: return "R3";
      endcase
   endfunction

   task automatic drive(input int crn, input int op1, input int crm, input int op2, input logic [31:0] d);
      iss_valid = 1'b1;
      iss_crn = 4'(crn); iss_op1 = 3'(op1); iss_crm = 4'(crm); iss_op2 = 3'(op2);
      iss_data = d;
   endtask

   task automatic step;
      @(negedge clk);
      #2;
   endtask

   task automatic run_one(input int crn, input int op1, input int crm, input int op2, input int kind);
      int c = want_cls(crn, op1, crm, op2);
      string t = tag_of(c);
      logic [31:0] d = {16'hA5C3, 4'(crn), 3'(op1), 1'b0, 4'(crm), 1'b0, 3'(op2)};
      bit rel;
      @(negedge clk);
      rel_ready = 1'b0;
      drive(crn, op1, crm, op2, d);
      #2 chk(rel_valid == (c == 0), t, 32'(rel_valid), 32'(c == 0));
      @(negedge clk); iss_valid = 1'b0;
      #2 chk(rel_valid == (c == 0), t, 32'(rel_valid), 32'(c == 0));
      rel = (c == 0);
      @(negedge clk); bar_dmb = 1'b1; step(); bar_dmb = 1'b0;
      @(negedge clk); #2 rel |= (c == 1);
      chk(rel_valid == rel, t, 32'(rel_valid), 32'(rel));
      bar_dsb = 1'b1; step(); bar_dsb = 1'b0;
      @(negedge clk); #2 rel |= (c == 1 || c == 2);
      chk(rel_valid == rel, t, 32'(rel_valid), 32'(rel));
      if (kind == 0) bar_isb = 1'b1; else if (kind == 1) exc_entry = 1'b1; else exc_return = 1'b1;
      step();
      bar_isb = 1'b0; exc_entry = 1'b0; exc_return = 1'b0;
      @(negedge clk); #2 rel |= (c != 4);
      chk(rel_valid == rel, t, 32'(rel_valid), 32'(rel));
      if (rel_valid) begin
         chk(rel_data == d, t, rel_data, d);
         chk(rel_crm == 4'(crm) && rel_op2 == 3'(op2), t, {rel_crm, 1'b0, rel_op2}, 32'((crm << 4) | op2));
         rel_ready = 1'b1;
         step();
         rel_ready = 1'b0;
         chk(rel_valid == 1'b0, "R7", 32'(rel_valid), 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int k = 0;
      repeat (3) @(negedge clk);
      #2;
      // R10 reset state
      chk(rel_valid == 1'b0, "R10", 32'(rel_valid), 0);
      chk(iss_stall == 1'b0, "R10", 32'(iss_stall), 0);
      rst_n = 1'b1;
      step();
      chk(rel_valid == 1'b0 && iss_stall == 1'b0, "R10", {rel_valid, iss_stall}, 0);

      // near-exhaustive class sweep
      for (int crm = 0; crm < 16; crm++)
         for (int op2 = 0; op2 < 8; op2++) begin
            run_one(7, 0, crm, op2, k % 3);
            k++;
         end
      for (int crn = 0; crn < 16; crn++)
         if (crn != 7) run_one(crn, 0, 5, 0, crn % 3);
      for (int op1 = 1; op1 < 8; op1++) run_one(7, op1, 6, 1, op1 % 3);

      // R6 deferral off: sync-class op passes same cycle
      @(negedge clk);
      defer_en = 1'b0; rel_ready = 1'b1;
      drive(7, 0, 5, 0, 32'h1111_0001);
      #2 chk(rel_valid && rel_data == 32'h1111_0001, "R6", rel_data, 32'h1111_0001);
      @(negedge clk); iss_valid = 1'b0;
      #2 chk(rel_valid == 1'b0, "R6", 32'(rel_valid), 0);
      // R9 hold while not ready
      @(negedge clk); rel_ready = 1'b0;
      drive(7, 0, 0, 0, 32'h2222_0002);
      step(); iss_valid = 1'b0;
      chk(rel_valid && rel_data == 32'h2222_0002, "R9", rel_data, 32'h2222_0002);
      step();
      chk(rel_valid && rel_data == 32'h2222_0002 && rel_crm == 4'd0, "R9", rel_data, 32'h2222_0002);
      rel_ready = 1'b1; step(); rel_ready = 1'b0;
      chk(rel_valid == 1'b0, "R9", 32'(rel_valid), 0);
      defer_en = 1'b1;

      // R11 barrier in the same cycle as its op
      @(negedge clk);
      drive(7, 0, 10, 2, 32'h3333_0003); bar_dmb = 1'b1;
      step(); iss_valid = 1'b0; bar_dmb = 1'b0;
      chk(rel_valid && rel_data == 32'h3333_0003, "R11", rel_data, 32'h3333_0003);
      rel_ready = 1'b1; step(); rel_ready = 1'b0;

      // R7 ordering: younger freed op waits behind older pending op
      @(negedge clk); drive(7, 0, 1, 0, 32'hAAAA_0000);
      @(negedge clk); drive(7, 0, 14, 2, 32'hBBBB_0000);
      @(negedge clk); iss_valid = 1'b0; bar_dmb = 1'b1;
      step(); bar_dmb = 1'b0;
      step();
      chk(rel_valid == 1'b0, "R7", 32'(rel_valid), 0);
      bar_dsb = 1'b1; step(); bar_dsb = 1'b0;
      step();
      chk(rel_valid && rel_data == 32'hAAAA_0000, "R7", rel_data, 32'hAAAA_0000);
      rel_ready = 1'b1; step();
      chk(rel_valid && rel_data == 32'hBBBB_0000, "R7", rel_data, 32'hBBBB_0000);
      step(); rel_ready = 1'b0;
      chk(rel_valid == 1'b0, "R7", 32'(rel_valid), 0);

      // R8 fill, stall, ignored issue, then barrier tuple drains
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk); drive(7, 0, 0, 0, 32'(100 + i));
      end
      step(); iss_valid = 1'b0;
      chk(iss_stall == 1'b1, "R8", 32'(iss_stall), 1);
      drive(7, 0, 0, 0, 32'd999);
      step(); iss_valid = 1'b0;
      chk(iss_stall == 1'b1 && rel_valid == 1'b0, "R8", {iss_stall, rel_valid}, 32'h2);
      drive(7, 0, 5, 4, 32'd777);
      step(); iss_valid = 1'b0;
      chk(rel_valid && rel_data == 32'd100, "R5", rel_data, 32'd100);
      rel_ready = 1'b1;
      for (int i = 1; i < DEPTH; i++) begin
         step();
         chk(rel_valid && rel_data == 32'(100 + i), "R8", rel_data, 32'(100 + i));
      end
      step(); rel_ready = 1'b0;
      chk(rel_valid == 1'b0 && iss_stall == 1'b0, "R8", {rel_valid, iss_stall}, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule